// File: doc/BRIEF.md
# Floating-Point Sign-Injection Unit

This unit handles the sign-injection family of floating-point operations for single and double precision. Each operand arrives as a 64-bit floating-point register value. The result takes its magnitude from the first operand. Its sign comes from the second operand in one of three ways:

- copied as it is,
- inverted,
- XORed with the first operand's own sign.

A 2-bit selector, taken from the instruction's rounding-mode field, picks the mode. A precision flag picks single or double.

Single-precision values are held NaN-boxed inside their 64-bit containers. Each single operand is checked for a proper box first. An operand whose upper half is not all ones is replaced by the canonical single NaN, 0x7FC00000, before its sign or magnitude is used. Every single-precision result is boxed again on the way out. Double-precision operands are used as they arrive, with no box check.

The computation is combinational and feeds one output register with a valid flag. The register has two states:

- **Empty** (`valid_out` low). Reset enters it, and so does any cycle with `valid_in` low.
- **Loaded** (`valid_out` high). An edge with `valid_in` high moves the register to Loaded, from either state.

Data is captured only on accepted edges, so `result` and `illegal_out` keep their last values while the register is Empty.

Top module: `fsgn_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `valid_out`, `result` and `illegal_out` to zero at the next rising edge, even if `valid_in` is high.
- R2: `valid_out` equals `valid_in` from the previous rising edge. `result` and `illegal_out` change only on an edge where `valid_in` is high, and otherwise hold their values.
- R3: In double precision (`is_double`=1) with code 0 (copy), `result` = {src_b[63], src_a[62:0]}.
- R4: In double precision with code 1 (negate), `result` = {~src_b[63], src_a[62:0]}.
- R5: In double precision with code 2 (XOR), `result` = {src_a[63]^src_b[63], src_a[62:0]}.
- R6: In single precision (`is_double`=0) with properly boxed operands, the sign is bit 31 and the magnitude is bits 30:0. Codes 0, 1 and 2 form bit 31 of `result` as copy, negate and XOR respectively.
- R7: In single precision, if either operand has bits 63:32 other than all ones, that operand is replaced by 0x7FC00000 before its sign and magnitude are used.
- R8: Every legal single-precision result has bits 63:32 all ones and the computed value in bits 31:0.
- R9: Code 3 sets `illegal_out` to 1 and forces `result` to zero. Codes 0 to 2 set `illegal_out` to 0.
- R10: In double precision the upper 32 bits of the operands are never checked for a box, so an operand whose upper half is not all ones is still used as it is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operands and controls are valid this cycle |
| op_sel | input | 2 | Injection code: 0 copy, 1 negate, 2 XOR, 3 illegal |
| is_double | input | 1 | 1 selects double precision, 0 selects single |
| src_a | input | 64 | First operand; supplies the magnitude |
| src_b | input | 64 | Second operand; supplies the sign |
| valid_out | output | 1 | Registered result is valid |
| result | output | 64 | Registered result |
| illegal_out | output | 1 | Registered flag for code 3 |

## Verification
The assertions check, on every cycle, the following:
- the one-cycle valid latency and the holding of data across idle cycles;
- the illegal flag and its zeroed result;
- double-precision copy injection;
- the all-ones upper half of single results;
- the replacement of badly boxed operands by the canonical NaN.

Only the bench's scenarios can show the following:
- the negate and XOR signs in both precisions;
- a NaN replacement that contributes only its sign through the second operand;
- double operands whose upper halves are not boxed;
- a reset that arrives while a valid operation is being accepted.

// File: rtl/fsgn_pkg.sv
package fsgn_pkg;

    typedef enum logic [1:0] {
        INJ_COPY   = 2'd0,
        INJ_NEGATE = 2'd1,
        INJ_XOR    = 2'd2,
        INJ_BAD    = 2'd3
    } inj_mode_e;

    localparam int unsigned FP_WIDTH = 64;
    localparam int unsigned SP_WIDTH = 32;
    localparam logic [SP_WIDTH-1:0] SP_CANON_NAN = 32'h7FC0_0000;

endpackage

// File: rtl/fsgn_unbox.sv
module fsgn_unbox #(
    parameter int unsigned FLEN = fsgn_pkg::FP_WIDTH,
    parameter int unsigned SLEN = fsgn_pkg::SP_WIDTH,
    parameter logic [SLEN-1:0] CANON = fsgn_pkg::SP_CANON_NAN
) (
    input  logic [FLEN-1:0] container,
    output logic [SLEN-1:0] value
);
    localparam int unsigned PAD = FLEN - SLEN;

    logic [PAD-1:0] upper;
    logic           box_ok;

    always_comb begin
        upper  = container[FLEN-1:SLEN];
        box_ok = &upper;
        value  = box_ok ? container[SLEN-1:0] : CANON;
    end
endmodule

// File: rtl/fsgn_decode.sv
module fsgn_decode
    import fsgn_pkg::*;
(
    input  logic [1:0] code,
    output inj_mode_e  mode,
    output logic       illegal
);
    always_comb begin
        mode    = inj_mode_e'(code);
        illegal = 1'b0;
        unique case (mode)
            INJ_COPY, INJ_NEGATE, INJ_XOR: illegal = 1'b0;
            INJ_BAD:                       illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/fsgn_inject.sv
module fsgn_inject
    import fsgn_pkg::*;
#(
    parameter int unsigned FLEN = FP_WIDTH,
    parameter int unsigned SLEN = SP_WIDTH
) (
    input  logic            is_double,
    input  inj_mode_e       mode,
    input  logic            illegal,
    input  logic [FLEN-1:0] a_full,
    input  logic [SLEN-1:0] a_sp,
    input  logic            b_sign_dp,
    input  logic            b_sign_sp,
    output logic [FLEN-1:0] res
);
    localparam int unsigned PAD = FLEN - SLEN;

    logic sign_a;
    logic sign_b;
    logic sign_new;

    always_comb begin
        sign_a = is_double ? a_full[FLEN-1] : a_sp[SLEN-1];
        sign_b = is_double ? b_sign_dp : b_sign_sp;
        unique case (mode)
            INJ_COPY:   sign_new = sign_b;
            INJ_NEGATE: sign_new = ~sign_b;
            INJ_XOR:    sign_new = sign_a ^ sign_b;
            INJ_BAD:    sign_new = 1'b0;
        endcase
        if (illegal) begin
            res = '0;
        end else if (is_double) begin
            res = {sign_new, a_full[FLEN-2:0]};
        end else begin
            res = {{PAD{1'b1}}, sign_new, a_sp[SLEN-2:0]};
        end
    end
endmodule

// File: rtl/fsgn_unit.sv
module fsgn_unit
    import fsgn_pkg::*;
#(
    parameter int unsigned FLEN = FP_WIDTH,
    parameter int unsigned SLEN = SP_WIDTH,
    parameter logic [SLEN-1:0] CANON = SP_CANON_NAN
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            valid_in,
    input  logic [1:0]      op_sel,
    input  logic            is_double,
    input  logic [FLEN-1:0] src_a,
    input  logic [FLEN-1:0] src_b,
    output logic            valid_out,
    output logic [FLEN-1:0] result,
    output logic            illegal_out
);
    localparam int unsigned NOPS = 2;

    logic [FLEN-1:0] src_vec [NOPS];
    logic [SLEN-1:0] sp_val  [NOPS];
    inj_mode_e       mode;
    logic            illegal_c;
    logic [FLEN-1:0] res_c;
    logic            past_ok;

    assign src_vec[0] = src_a;
    assign src_vec[1] = src_b;

    for (genvar gi = 0; gi < NOPS; gi++) begin : g_unbox
        fsgn_unbox #(
            .FLEN (FLEN),
            .SLEN (SLEN),
            .CANON(CANON)
        ) u_unbox (
            .container(src_vec[gi]),
            .value    (sp_val[gi])
        );
    end

    fsgn_decode u_decode (
        .code   (op_sel),
        .mode   (mode),
        .illegal(illegal_c)
    );

    fsgn_inject #(
        .FLEN(FLEN),
        .SLEN(SLEN)
    ) u_inject (
        .is_double(is_double),
        .mode     (mode),
        .illegal  (illegal_c),
        .a_full   (src_a),
        .a_sp     (sp_val[0]),
        .b_sign_dp(src_b[FLEN-1]),
        .b_sign_sp(sp_val[1][SLEN-1]),
        .res      (res_c)
    );

    // Output register: Empty when valid_out is low, Loaded when high.
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_out   <= 1'b0;
            result      <= '0;
            illegal_out <= 1'b0;
        end else begin
            valid_out <= valid_in;
            if (valid_in) begin
                result      <= res_c;
                illegal_out <= illegal_c;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (valid_out == $past(valid_in)));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(valid_in)) |-> ($stable(result) && $stable(illegal_out)));

    assert_illegal_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(valid_in)) |-> (illegal_out == ($past(op_sel) == 2'b11)));

    assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (valid_out && illegal_out) |-> (result == '0));

    assert_dp_copy_R3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(valid_in && is_double && op_sel == 2'b00))
        |-> (result == {$past(src_b[FLEN-1]), $past(src_a[FLEN-2:0])}));

    assert_sp_boxed_R8: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(valid_in && !is_double && op_sel != 2'b11))
        |-> (&result[FLEN-1:SLEN]));

    assert_unbox_a_R7: assert property (@(posedge clk) disable iff (rst)
        (&src_a[FLEN-1:SLEN]) || (sp_val[0] == CANON));

    assert_unbox_b_R7: assert property (@(posedge clk) disable iff (rst)
        (&src_b[FLEN-1:SLEN]) || (sp_val[1] == CANON));

    assert_sp_nan_mag_R7: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(valid_in && !is_double && op_sel != 2'b11 && !(&src_a[FLEN-1:SLEN])))
        |-> (result[SLEN-2:0] == CANON[SLEN-2:0]));

endmodule

// File: tb/test_fsgn_unit.sv
module test_fsgn_unit;

    typedef struct packed {
        logic [3:0]  req;
        logic        dbl;
        logic [1:0]  op;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
        logic        ill;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        // R3 double copy, R4 negate, R5 XOR
        '{4'd3,  1'b1, 2'd0, 64'h3FF0_0000_0000_0000, 64'hC000_0000_0000_0000, 64'hBFF0_0000_0000_0000, 1'b0},
        '{4'd4,  1'b1, 2'd1, 64'h3FF0_0000_0000_0000, 64'hC000_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1'b0},
        '{4'd5,  1'b1, 2'd2, 64'h3FF0_0000_0000_0000, 64'hC000_0000_0000_0000, 64'hBFF0_0000_0000_0000, 1'b0},
        '{4'd3,  1'b1, 2'd0, 64'hC008_0000_0000_0000, 64'h4000_0000_0000_0000, 64'h4008_0000_0000_0000, 1'b0},
        '{4'd4,  1'b1, 2'd1, 64'hC008_0000_0000_0000, 64'h4000_0000_0000_0000, 64'hC008_0000_0000_0000, 1'b0},
        '{4'd5,  1'b1, 2'd2, 64'hC008_0000_0000_0000, 64'h4000_0000_0000_0000, 64'hC008_0000_0000_0000, 1'b0},
        // R10 double with unboxed-looking upper halves
        '{4'd10, 1'b1, 2'd0, 64'h0000_0000_4049_0FDB, 64'h8000_0000_0000_0000, 64'h8000_0000_4049_0FDB, 1'b0},
        // R6 single, boxed operands (R8 box on result)
        '{4'd6,  1'b0, 2'd0, 64'hFFFF_FFFF_3F80_0000, 64'hFFFF_FFFF_C000_0000, 64'hFFFF_FFFF_BF80_0000, 1'b0},
        '{4'd6,  1'b0, 2'd1, 64'hFFFF_FFFF_3F80_0000, 64'hFFFF_FFFF_C000_0000, 64'hFFFF_FFFF_3F80_0000, 1'b0},
        '{4'd6,  1'b0, 2'd2, 64'hFFFF_FFFF_3F80_0000, 64'hFFFF_FFFF_C000_0000, 64'hFFFF_FFFF_BF80_0000, 1'b0},
        '{4'd8,  1'b0, 2'd2, 64'hFFFF_FFFF_C040_0000, 64'hFFFF_FFFF_C000_0000, 64'hFFFF_FFFF_4040_0000, 1'b0},
        // R7 bad box on first, second, both operands
        '{4'd7,  1'b0, 2'd0, 64'h0000_0000_3F80_0000, 64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_FFC0_0000, 1'b0},
        '{4'd7,  1'b0, 2'd1, 64'hFFFF_FFFF_3F80_0000, 64'hFFFF_FFFE_8000_0000, 64'hFFFF_FFFF_BF80_0000, 1'b0},
        '{4'd7,  1'b0, 2'd2, 64'h1234_5678_BF80_0000, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_7FC0_0000, 1'b0},
        // R9 illegal code in both precisions
        '{4'd9,  1'b1, 2'd3, 64'h3FF0_0000_0000_0000, 64'hC000_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b1},
        '{4'd9,  1'b0, 2'd3, 64'hFFFF_FFFF_3F80_0000, 64'hFFFF_FFFF_C000_0000, 64'h0000_0000_0000_0000, 1'b1},
        '{4'd5,  1'b1, 2'd2, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        valid_in;
    logic [1:0]  op_sel;
    logic        is_double;
    logic [63:0] src_a;
    logic [63:0] src_b;
    logic        valid_out;
    logic [63:0] result;
    logic        illegal_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fsgn_unit i_fsgn_unit (
        .clk        (clk),
        .rst        (rst),
        .valid_in   (valid_in),
        .op_sel     (op_sel),
        .is_double  (is_double),
        .src_a      (src_a),
        .src_b      (src_b),
        .valid_out  (valid_out),
        .result     (result),
        .illegal_out(illegal_out)
    );

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; valid_in = 1'b1; op_sel = 2'd0; is_double = 1'b1;
        src_a = 64'h3FF0_0000_0000_0000; src_b = 64'h8000_0000_0000_0000;
        repeat (3) @(negedge clk);
        // R1 reset state, even with valid_in high
        check("R1", "valid_out", {63'd0, valid_out}, 64'd0);
        check("R1", "result", result, 64'd0);
        check("R1", "illegal_out", {63'd0, illegal_out}, 64'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            valid_in  = 1'b1;
            is_double = VECS[i].dbl;
            op_sel    = VECS[i].op;
            src_a     = VECS[i].a;
            src_b     = VECS[i].b;
            @(negedge clk);
            check($sformatf("R%0d", VECS[i].req), "result", result, VECS[i].exp);
            check($sformatf("R%0d", VECS[i].req), "illegal_out", {63'd0, illegal_out}, {63'd0, VECS[i].ill});
            check("R2", "valid_out", {63'd0, valid_out}, 64'd1);
        end

        // R2 hold when valid_in is low, across two idle cycles
        valid_in = 1'b0; op_sel = 2'd3; src_a = 64'hDEAD_BEEF_0000_0000;
        @(negedge clk);
        check("R2", "idle valid_out", {63'd0, valid_out}, 64'd0);
        check("R2", "idle result", result, VECS[NV-1].exp);
        check("R2", "idle illegal_out", {63'd0, illegal_out}, 64'd0);
        @(negedge clk);
        check("R2", "idle result 2", result, VECS[NV-1].exp);

        // R2 latency: accepted again after idle
        valid_in = 1'b1; is_double = 1'b1; op_sel = 2'd1;
        src_a = 64'h4000_0000_0000_0000; src_b = 64'h0;
        @(negedge clk);
        check("R2", "reload valid_out", {63'd0, valid_out}, 64'd1);
        check("R4", "reload result", result, 64'hC000_0000_0000_0000);

        // R1 reset while a valid operation is presented
        rst = 1'b1; op_sel = 2'd3;
        @(negedge clk);
        check("R1", "mid valid_out", {63'd0, valid_out}, 64'd0);
        check("R1", "mid result", result, 64'd0);
        check("R1", "mid illegal_out", {63'd0, illegal_out}, 64'd0);
        rst = 1'b0; valid_in = 1'b0;
        @(negedge clk);
        check("R2", "post-reset idle", {63'd0, valid_out}, 64'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule